// File: doc/BRIEF.md
# Oversampling serial receiver with framing-error resynchronization

This block recovers asynchronous serial characters from a single receive line. The line is sampled on every pulse of a sample enable, and that enable runs at sixteen times the bit rate. A character has one low start bit, eight data bits sent least significant first, and one high stop bit. When a character completes, the received byte appears on a parallel output. A receive-full flag and a framing-error flag are raised at the same moment. One read strobe clears both flags.

The block is built for how it recovers once the stop bit is missing. A missing stop bit on an ordinary character is taken as the start of the next character: the receiver keeps its bit phase and carries on into start-bit handling, with no wait for a falling edge. A missing stop bit on a character whose data bits are all zero is a break. After a break the receiver will not accept any start until it has seen the line high. The output has no back-pressure. The full flag acts as the valid indication, and the read strobe acts as the acknowledge. A character that completes while the full flag is still set overwrites the byte and keeps the flag set.

Top module: `uart_rx_resync`

## Requirements
- R1: After reset, rdrf and fe are 0 and rx_data is 0. No start is accepted until the line has been sampled high, so a line held low from reset produces no character.
- R2: One bit lasts 16 sample ticks. Counting from the tick where the start edge is seen (count 0), each data bit and the stop bit is decided by the 2-of-3 majority of the samples at counts 8, 9 and 10 of its bit period. Data bits arrive LSB first. A character with a high stop bit gives rx_data equal to the byte, rdrf = 1 and fe = 0.
- R3: Start verification uses the samples at counts 3, 5 and 7. If two or more of them are high, the start is rejected as noise and no character is produced.
- R4: rdrf and fe change together on the stop-decision tick, and fe is 1 exactly when the stop majority is low. A one-cycle rd_clr pulse clears both flags and leaves rx_data unchanged. If a character completes in the same cycle as rd_clr, the completing character wins.
- R5: A character that completes while rdrf is 1 replaces rx_data, and rdrf stays 1.
- R6: On a framing error with nonzero data, if the line is low on the stop-decision tick, that tick counts as count 10 of a new start bit. The next character's data is then sampled in phase with no further falling edge.
- R7: On a framing error with nonzero data, if the line is high on the stop-decision tick, the receiver returns to edge hunting. A steady high line then produces no character, and a later real start is received normally.
- R8: A framing error with all data bits zero is a break. rx_data reads 0 and both flags are set. No start is accepted, however long the line stays low, until the line has been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_in | input | 1 | Asynchronous receive line, idle high |
| sample_en | input | 1 | One-cycle pulse at 16 times the bit rate |
| rd_clr | input | 1 | One-cycle strobe that clears rdrf and fe |
| rx_data | output | 8 | Last received byte |
| rdrf | output | 1 | A received byte is waiting |
| fe | output | 1 | The last character had a low stop bit |

## Verification
The bench uses the default parameters: 16 ticks per bit, eight data bits and a two-stage line synchronizer. It pulses sample_en once every four clocks and changes the line only at the start of a tick slot. This puts each tick count under the bench's control, so it can drop the stop bit low for exactly ten ticks. That reaches the case where the stop majority is low but the line is high on the decision tick. It can also hold a stop bit low into a full following character, which exercises the phase-preserving artificial start.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take_a,
  input  logic take_b,
  input  logic line,
  output logic vote
);
  import uart_rx_pkg::*;
  logic a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else if (tick) begin
      if (take_a) a_q <= line;
      if (take_b) b_q <= line;
    end
  end

  // Third sample is the live line on the deciding tick
  assign vote = maj3(a_q, b_q, line);
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl #(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 vote,
  output logic                 take_a,
  output logic                 take_b,
  output logic                 frame_done,
  output logic                 frame_stop,
  output logic [DATA_BITS-1:0] frame_data,
  output logic                 hunting,
  output logic                 armed
);
  import uart_rx_pkg::*;

  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] ST_A = CNT_W'(OSR/4 - 1);
  localparam logic [CNT_W-1:0] ST_B = CNT_W'(OSR/4 + 1);
  localparam logic [CNT_W-1:0] ST_C = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] BT_A = CNT_W'(OSR/2);
  localparam logic [CNT_W-1:0] BT_B = CNT_W'(OSR/2 + 1);
  localparam logic [CNT_W-1:0] BT_C = CNT_W'(OSR/2 + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  rx_state_t              state;
  logic [CNT_W-1:0]       cnt;
  logic [BIT_W-1:0]       bit_idx;
  logic [DATA_BITS-1:0]   shreg, shifted;
  logic                   in_bit;

  assign in_bit = (state == ST_DATA) || (state == ST_STOP);

  always_comb begin
    take_a = (state == ST_START) ? (cnt == ST_A) : (in_bit && cnt == BT_A);
    take_b = (state == ST_START) ? (cnt == ST_B) : (in_bit && cnt == BT_B);
    shifted = shreg >> 1;
    shifted[DATA_BITS-1] = vote;
  end

  assign frame_done = tick && (state == ST_STOP) && (cnt == BT_C);
  assign frame_stop = vote;
  assign frame_data = shreg;
  assign hunting    = (state == ST_HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      armed   <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_HUNT: begin
          if (line) armed <= 1'b1;
          else if (armed) begin
            state <= ST_START;
            cnt   <= CNT_W'(1);
            armed <= 1'b0;
          end
        end
        ST_START: begin
          cnt <= cnt + 1'b1;
          if (cnt == ST_C && vote) begin
            state <= ST_HUNT;
            cnt   <= '0;
            armed <= line;
          end else if (cnt == LAST) begin
            state   <= ST_DATA;
            cnt     <= '0;
            bit_idx <= '0;
          end
        end
        ST_DATA: begin
          cnt <= cnt + 1'b1;
          if (cnt == BT_C) shreg <= shifted;
          if (cnt == LAST) begin
            cnt <= '0;
            if (bit_idx == LAST_BIT) state <= ST_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_STOP: begin
          cnt <= cnt + 1'b1;
          if (cnt == BT_C) begin
            if (vote) begin
              state <= ST_HUNT;
              cnt   <= '0;
              armed <= line;
            end else if (shreg == '0) begin
              state <= ST_HUNT;          // break: wait for idle high
              cnt   <= '0;
              armed <= 1'b0;
            end else if (!line) begin
              state <= ST_START;         // artificial start, phase kept
              armed <= 1'b0;
            end else begin
              state <= ST_HUNT;
              cnt   <= '0;
              armed <= 1'b1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic                 stop_bit,
  input  logic [DATA_BITS-1:0] data_in,
  input  logic                 rd_clr,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 full,
  output logic                 ferr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      full     <= 1'b0;
      ferr     <= 1'b0;
    end else if (done) begin
      data_out <= data_in;
      full     <= 1'b1;
      ferr     <= !stop_bit;
    end else if (rd_clr) begin
      full <= 1'b0;
      ferr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_resync.sv
module uart_rx_resync #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 serial_in,
  input  logic                 sample_en,
  input  logic                 rd_clr,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rdrf,
  output logic                 fe
);
  logic                 line, vote, take_a, take_b;
  logic                 frame_done, frame_stop, hunting, armed;
  logic [DATA_BITS-1:0] frame_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(serial_in), .q(line)
  );

  uart_rx_vote u_vote (
    .clk(clk), .rst_n(rst_n), .tick(sample_en), .take_a(take_a),
    .take_b(take_b), .line(line), .vote(vote)
  );

  uart_rx_ctrl #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(sample_en), .line(line), .vote(vote),
    .take_a(take_a), .take_b(take_b), .frame_done(frame_done),
    .frame_stop(frame_stop), .frame_data(frame_data), .hunting(hunting),
    .armed(armed)
  );

  uart_rx_flags #(.DATA_BITS(DATA_BITS)) u_flags (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .stop_bit(frame_stop),
    .data_in(frame_data), .rd_clr(rd_clr), .data_out(rx_data),
    .full(rdrf), .ferr(fe)
  );
endmodule

// File: rtl/uart_rx_resync_chk.sv
module uart_rx_resync_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_en,
  input logic                 rd_clr,
  input logic                 line,
  input logic                 rdrf,
  input logic                 fe,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 frame_done,
  input logic                 frame_stop,
  input logic [DATA_BITS-1:0] frame_data,
  input logic                 hunting,
  input logic                 armed
);
  assert_fe_with_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fe |-> rdrf);

  assert_set_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdrf) |-> $past(sample_en));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !frame_done) |=> (!rdrf && !fe));

  assert_data_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $past(frame_done));

  assert_artificial_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_stop && frame_data != '0 && !line) |=> !hunting);

  assert_break_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_stop && frame_data == '0) |=> (hunting && !armed));

  assert_unarmed_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && !armed) |=> hunting);
endmodule

bind uart_rx_resync uart_rx_resync_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rd_clr(rd_clr),
  .line(line), .rdrf(rdrf), .fe(fe), .rx_data(rx_data),
  .frame_done(frame_done), .frame_stop(frame_stop), .frame_data(frame_data),
  .hunting(hunting), .armed(armed)
);

// File: tb/uart_rx_resync_bench.sv
module uart_rx_resync_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serial_in = 1'b0;
  logic       sample_en = 1'b0;
  logic       rd_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rdrf, fe;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  uart_rx_resync u_uart_rx_resync (
    .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .sample_en(sample_en),
    .rd_clr(rd_clr), .rx_data(rx_data), .rdrf(rdrf), .fe(fe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [7:0] d,
                         input logic full, input logic ferr);
    chk(req, "rx_data", {24'd0, rx_data}, {24'd0, d});
    chk(req, "rdrf", {31'd0, rdrf}, {31'd0, full});
    chk(req, "fe", {31'd0, fe}, {31'd0, ferr});
  endtask

  // One tick slot: line set at slot start, tick on the fourth edge
  task automatic send_slots(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      serial_in = v;
      sample_en = 1'b0;
      repeat (3) @(posedge clk);
      #1 sample_en = 1'b1;
      @(posedge clk);
      #1 sample_en = 1'b0;
    end
  endtask

  task automatic send_body(input logic [7:0] d);
    send_slots(1'b0, 16);
    for (int b = 0; b < 8; b++) send_slots(d[b], 16);
  endtask

  task automatic send_frame(input logic [7:0] d);
    send_body(d);
    send_slots(1'b1, 16);
    send_slots(1'b1, 4);
  endtask

  task automatic pulse_clr();
    rd_clr = 1'b1;
    @(posedge clk);
    #1 rd_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1", 8'h00, 1'b0, 1'b0);
    send_slots(1'b0, 200);
    chk("R1", "rdrf low line from reset", {31'd0, rdrf}, 32'd0);
    send_slots(1'b1, 20);
  endtask

  task automatic t_normal();
    send_frame(8'hA5);
    chk_out("R2", 8'hA5, 1'b1, 1'b0);
    pulse_clr();
    chk_out("R4", 8'hA5, 1'b0, 1'b0);
    send_frame(8'h01);
    chk_out("R2", 8'h01, 1'b1, 1'b0);
    pulse_clr();
  endtask

  task automatic t_overwrite();
    send_frame(8'h12);
    send_frame(8'h34);
    chk_out("R5", 8'h34, 1'b1, 1'b0);
    pulse_clr();
  endtask

  task automatic t_noise();
    send_slots(1'b0, 2);
    send_slots(1'b1, 200);
    chk("R3", "rdrf after glitch", {31'd0, rdrf}, 32'd0);
  endtask

  task automatic t_artificial();
    send_body(8'h55);
    send_slots(1'b0, 11);
    chk_out("R6", 8'h55, 1'b1, 1'b1);
    pulse_clr();
    send_slots(1'b0, 5);
    for (int b = 0; b < 8; b++) send_slots(b == 1 || b == 2 || b == 4 || b == 7, 16);
    send_slots(1'b1, 20);
    chk_out("R6", 8'h96, 1'b1, 1'b0);
    pulse_clr();
  endtask

  task automatic t_high_after_fe();
    send_body(8'h5A);
    send_slots(1'b0, 10);
    send_slots(1'b1, 1);
    chk_out("R7", 8'h5A, 1'b1, 1'b1);
    pulse_clr();
    send_slots(1'b1, 200);
    chk("R7", "rdrf on idle line", {31'd0, rdrf}, 32'd0);
    send_frame(8'hC3);
    chk_out("R7", 8'hC3, 1'b1, 1'b0);
    pulse_clr();
  endtask

  task automatic t_break();
    send_body(8'h00);
    send_slots(1'b0, 11);
    chk_out("R8", 8'h00, 1'b1, 1'b1);
    pulse_clr();
    send_slots(1'b0, 200);
    chk("R8", "rdrf while low after break", {31'd0, rdrf}, 32'd0);
    send_slots(1'b1, 2);
    send_frame(8'h81);
    chk_out("R8", 8'h81, 1'b1, 1'b0);
    pulse_clr();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_normal();
    t_overwrite();
    t_noise();
    t_artificial();
    t_high_after_fe();
    t_break();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule